// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block is a 7-bit down-counting watchdog that software must service inside a time slot. The counter steps down once per prescaler period while the watchdog is armed. If the counter falls through the 0x40 boundary, a reset is requested. Servicing the watchdog is done by writing a new count into the control register. If that write arrives while the count is still above the programmed window value, the block treats it as a fault and requests a reset.

Arming is one-way. It happens through a control-register write or through a strap input that models a nonvolatile start-up option. Only the block's own reset request, or the system reset, can return the watchdog to the disarmed state.

The reset request is a single-cycle pulse. When the pulse appears, the counter and the window have already been put back to their start values, so the surrounding reset logic sees a watchdog that has been cleaned up.

Top module: `win_watchdog`

## Requirements
- R1: After reset, count_o and window_o read 0x7F, armed_o is 0 and reset_req_o is 0.
- R2: A write with wr_sel=0 (the control register) loads count from wr_data[6:0] and sets the arm flag when wr_data[7]=1. Writing wr_data[7]=0 never clears the arm flag.
- R3: While opt_arm is 1, the block arms on the next clock. Once armed, it stays armed after opt_arm returns to 0, and stays armed after control writes.
- R4: While armed, the count decreases by one every PRESCALE clocks, counted from the last control write or arming write. While disarmed, the count holds its value.
- R5: When the armed count steps from 0x40 to 0x3F, reset_req_o goes high on the following clock. With the count loaded to C by an arming write, the pulse appears (C-63)*PRESCALE+1 clocks after that write.
- R6: A control write while armed and while the count is greater than window_o causes reset_req_o on the next clock.
- R7: A control write while armed, with the count less than or equal to window_o and wr_data[6]=1, reloads the count from wr_data[6:0] and requests no reset.
- R8: A control write with wr_data[6]=0, made while armed or made together with wr_data[7]=1, causes reset_req_o on the next clock.
- R9: reset_req_o lasts exactly one clock. While it is high, count_o and window_o read 0x7F, and armed_o equals the current opt_arm value.
- R10: A write with wr_sel=1 stores wr_data[6:0] as the window. A control write while disarmed loads the count without any window check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opt_arm | input | 1 | Start-up arming strap from nonvolatile option |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 control, 1 window |
| wr_data | input | 8 | Write data; bit 7 arm, bits 6:0 value |
| count_o | output | 7 | Current counter value |
| window_o | output | 7 | Current window value |
| armed_o | output | 1 | Watchdog armed flag |
| reset_req_o | output | 1 | One-cycle reset request |

## Verification
The table of vectors places refreshes at chosen tick counts on both sides of the window. It includes the case where the count equals the window exactly. A design that used greater-or-equal instead of greater-than would reset on that equal-count refresh, which is legal.

Directed cases cover several other errors:
- Exact cycle of the timeout pulse: a design that counted one period short or fired at 0x40 shows up as an off-by-one in cycles.
- A low reload value: a design that accepted it would let the count sit below the timeout point without ever firing.
- Clear-on-zero writes to the arm bit, and arming through the strap with an expired count: designs that got these wrong would silently disarm, or miss the immediate fault.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;

  localparam int CNT_W = 7;

  typedef logic [CNT_W-1:0] count_t;

  localparam count_t CNT_INIT = '1;
  localparam count_t WIN_INIT = '1;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_WIN  = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic expired;
    logic early;
    logic low_load;
  } fault_t;

  // top bit set means the count is still above the timeout point
  function automatic logic count_live(count_t c);
    return c[CNT_W-1];
  endfunction

  function automatic logic refresh_too_early(count_t c, count_t w);
    return c > w;
  endfunction

  function automatic count_t count_step(count_t c);
    return c - count_t'(1);
  endfunction

endpackage

// File: rtl/wwdg_prescaler.sv
module wwdg_prescaler #(
  parameter int PRESCALE = 12288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);

  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (restart || !run) begin
      pcnt <= '0;
    end else if (pcnt == LAST) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + PW'(1);
    end
  end

  assign tick = run && (pcnt == LAST);

  generate
    if (PRESCALE > 1) begin : g_gap
      // R4: ticks are never back to back when the period is longer than one clock
      assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/wwdg_fault.sv
module wwdg_fault
  import wwdg_pkg::*;
(
  input  logic   armed,
  input  count_t cnt,
  input  count_t win,
  input  logic   ctrl_wr,
  input  logic   wr_arm,
  input  count_t wr_cnt,
  output fault_t causes,
  output logic   fault_any
);

  always_comb begin
    causes          = '0;
    causes.expired  = armed && !count_live(cnt);
    causes.early    = ctrl_wr && armed && refresh_too_early(cnt, win);
    causes.low_load = ctrl_wr && (armed || wr_arm) && !count_live(wr_cnt);
  end

  assign fault_any = causes.expired | causes.early | causes.low_load;

endmodule

// File: rtl/wwdg_core.sv
module wwdg_core
  import wwdg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fault,
  input  logic   ctrl_wr,
  input  logic   win_wr,
  input  logic   wr_arm,
  input  count_t wr_cnt,
  input  logic   opt_arm,
  input  logic   tick,
  output count_t cnt,
  output count_t win,
  output logic   armed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= CNT_INIT;
      win   <= WIN_INIT;
      armed <= 1'b0;
    end else if (fault) begin
      cnt   <= CNT_INIT;
      win   <= WIN_INIT;
      armed <= opt_arm;
    end else begin
      armed <= armed | opt_arm | (ctrl_wr & wr_arm);
      if (ctrl_wr) begin
        cnt <= wr_cnt;
      end else if (armed && tick) begin
        cnt <= count_step(cnt);
      end
      if (win_wr) begin
        win <= wr_cnt;
      end
    end
  end

  // R3: arming is sticky until a fault
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !fault) |=> armed);

  // R4: one step per tick while armed
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tick && !fault && !ctrl_wr) |=> (cnt == count_step($past(cnt))));

  // R4: count frozen while disarmed
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !ctrl_wr && !fault) |=> $stable(cnt));

  // R10: window write lands
  assert_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && !fault) |=> (win == $past(wr_cnt)));

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wwdg_pkg::*;
#(
  parameter int PRESCALE = 12288
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 opt_arm,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [CNT_W:0]       wr_data,
  output logic [CNT_W-1:0]     count_o,
  output logic [CNT_W-1:0]     window_o,
  output logic                 armed_o,
  output logic                 reset_req_o
);

  reg_sel_e sel;
  logic     ctrl_wr;
  logic     win_wr;
  logic     wr_arm;
  count_t   wr_cnt;
  count_t   cnt;
  count_t   win;
  logic     armed;
  logic     tick;
  fault_t   causes;
  logic     fault_any;
  logic     req_q;

  assign sel     = reg_sel_e'(wr_sel);
  assign ctrl_wr = wr_en && (sel == SEL_CTRL);
  assign win_wr  = wr_en && (sel == SEL_WIN);
  assign wr_arm  = wr_data[CNT_W];
  assign wr_cnt  = wr_data[CNT_W-1:0];

  wwdg_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (armed),
    .restart (ctrl_wr | fault_any),
    .tick    (tick)
  );

  wwdg_fault u_fault (
    .armed     (armed),
    .cnt       (cnt),
    .win       (win),
    .ctrl_wr   (ctrl_wr),
    .wr_arm    (wr_arm),
    .wr_cnt    (wr_cnt),
    .causes    (causes),
    .fault_any (fault_any)
  );

  wwdg_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .fault   (fault_any),
    .ctrl_wr (ctrl_wr),
    .win_wr  (win_wr),
    .wr_arm  (wr_arm),
    .wr_cnt  (wr_cnt),
    .opt_arm (opt_arm),
    .tick    (tick),
    .cnt     (cnt),
    .win     (win),
    .armed   (armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= fault_any;
    end
  end

  assign count_o     = cnt;
  assign window_o    = win;
  assign armed_o     = armed;
  assign reset_req_o = req_q;

  // R9: the request is a single clock wide
  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |=> !reset_req_o);

  // R9: registers are back at start values while requesting
  assert_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> (count_o == CNT_INIT && window_o == WIN_INIT));

  // R5: falling through the timeout point requests reset
  assert_expired_R5: assert property (@(posedge clk) disable iff (!rst_n)
    causes.expired |=> reset_req_o);

  // R6: early service requests reset
  assert_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    causes.early |=> reset_req_o);

  // R8: reload below the timeout point requests reset
  assert_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    causes.low_load |=> reset_req_o);

endmodule

// File: tb/tb_win_watchdog.sv
module tb_win_watchdog;

  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       opt_arm = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [6:0] count_o;
  logic [6:0] window_o;
  logic       armed_o;
  logic       reset_req_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  win_watchdog #(.PRESCALE(P)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .opt_arm     (opt_arm),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .count_o     (count_o),
    .window_o    (window_o),
    .armed_o     (armed_o),
    .reset_req_o (reset_req_o)
  );

  // fields: window, start count, ticks before service, service value
  localparam logic [27:0] VEC [8] = '{
    {7'h7F, 7'h7F, 7'd0,  7'h7F},
    {7'h50, 7'h70, 7'd5,  7'h70},
    {7'h50, 7'h70, 7'd32, 7'h65},
    {7'h50, 7'h70, 7'd33, 7'h7F},
    {7'h60, 7'h7F, 7'd16, 7'h7F},
    {7'h7F, 7'h45, 7'd2,  7'h3F},
    {7'h40, 7'h41, 7'd1,  7'h41},
    {7'h00, 7'h7F, 7'd0,  7'h7F}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    opt_arm = 1'b0;
    wr_en   = 1'b0;
    rst_n   = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung run expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int got;
    do_reset();
    // R1 reset state
    check("R1 count", int'(count_o), 'h7F);
    check("R1 window", int'(window_o), 'h7F);
    check("R1 armed", int'(armed_o), 0);
    check("R1 req", int'(reset_req_o), 0);

    // table of service scenarios
    for (int i = 0; i < 8; i++) begin
      logic [6:0] w, c, k, r;
      int         cur;
      logic       exp_fault;
      {w, c, k, r} = VEC[i];
      do_reset();
      wr(1'b1, {1'b0, w});
      wr(1'b0, {1'b1, c});
      repeat (int'(k) * P) @(negedge clk);
      cur = int'(c) - int'(k);
      check("R4 count before service", int'(count_o), cur);
      wr(1'b0, {1'b1, r});
      exp_fault = (cur > int'(w)) || !r[6];
      if (cur > int'(w)) check("R6 early service", int'(reset_req_o), 1);
      else if (!r[6])    check("R8 low reload", int'(reset_req_o), 1);
      else begin
        check("R7 in-window service", int'(reset_req_o), 0);
        check("R7 reload value", int'(count_o), int'(r));
        check("R7 still armed", int'(armed_o), 1);
      end
      if (exp_fault) check("R9 count restored", int'(count_o), 'h7F);
    end

    // R4 step rate
    do_reset();
    wr(1'b0, 8'hFF);
    repeat (P - 1) @(negedge clk);
    check("R4 no step yet", int'(count_o), 'h7F);
    @(negedge clk);
    check("R4 one step", int'(count_o), 'h7E);

    // R10 disarmed load without window check, R4 hold
    do_reset();
    wr(1'b1, 8'h00);
    check("R10 window stored", int'(window_o), 'h00);
    wr(1'b0, 8'h55);
    check("R10 no fault disarmed", int'(reset_req_o), 0);
    check("R10 disarmed load", int'(count_o), 'h55);
    repeat (20) @(negedge clk);
    check("R4 disarmed hold", int'(count_o), 'h55);

    // R2 arm bit is set-only
    do_reset();
    wr(1'b0, 8'hFF);
    wr(1'b0, 8'h7E);
    check("R2 still armed", int'(armed_o), 1);
    check("R2 no fault", int'(reset_req_o), 0);
    check("R2 loaded", int'(count_o), 'h7E);

    // R5 timeout timing and R9 restore
    do_reset();
    wr(1'b1, 8'h50);
    wr(1'b0, 8'hC8);
    got = -1;
    for (int n = 1; n <= 2000; n++) begin
      @(negedge clk);
      if (reset_req_o) begin
        got = n;
        break;
      end
    end
    check("R5 timeout cycle", got, (8'h48 - 63) * P + 1);
    check("R9 count restored", int'(count_o), 'h7F);
    check("R9 window restored", int'(window_o), 'h7F);
    check("R9 disarmed", int'(armed_o), 0);
    @(negedge clk);
    check("R9 single pulse", int'(reset_req_o), 0);

    // R8 arming write with low value
    do_reset();
    wr(1'b0, 8'hA0);
    check("R8 arming low reload", int'(reset_req_o), 1);

    // R3 strap arming with expired count
    do_reset();
    wr(1'b0, 8'h30);
    opt_arm = 1'b1;
    @(negedge clk);
    check("R3 strap arms", int'(armed_o), 1);
    check("R3 no request yet", int'(reset_req_o), 0);
    @(negedge clk);
    check("R5 expired on arm", int'(reset_req_o), 1);
    check("R9 armed follows strap", int'(armed_o), 1);
    check("R9 count restored", int'(count_o), 'h7F);
    opt_arm = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 sticky after strap", int'(armed_o), 1);
    wr(1'b0, 8'h7F);
    check("R3 sticky after write", int'(armed_o), 1);
    check("R7 no fault", int'(reset_req_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule